// File: doc/BRIEF.md
# Key-Protected Power Mode Controller

This block holds the power and core-clock settings of a small microcontroller behind a simple register write/read port. An 8-bit control register carries an enable for each of four power domains (crystal, PLL, peripherals, core) and a 3-bit select for the core-clock divider. A 0 in an enable bit means that domain is powered down. Software can change the register only with an unlock sequence. It first writes a fixed key value to a separate write-only key register. The very next bus write must then go to the control register.

The block also enforces the legal power-down orderings. The peripherals may go down only together with the core. The PLL may go down only together with both the core and the peripherals. A wake-up event restores the core, peripheral and PLL domains in hardware.

From the 10.24 MHz reference clock, the block produces a one-cycle core-clock enable at the reference rate divided by a power of two. A divider change is applied only at the end of the current period, so the enable never produces a shortened interval.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the control register reads 0x7B: crystal (bit 6), PLL (bit 5), peripheral (bit 4) and core (bit 3) enables all 1, and divide select (bits 2:0) equal to 3. The domain outputs show the same values.
- R2: A control-register write (address 1) is accepted only when the immediately preceding bus write went to the key register (address 0) with the value 0x01. An accepted value is visible on the read port and on the domain outputs one clock after the write.
- R3: A control write without a valid unlock leaves the register unchanged. Any of the following cancels the unlock: a write to any other address, a key write of a value other than 0x01, or any control write (accepted or rejected). Without a write to address 1 or a wake-up, the register holds its value.
- R4: An unlocked write that clears the peripheral enable (bit 4) while keeping the core enable (bit 3) set is rejected as a whole, and no field changes.
- R5: An unlocked write that clears the PLL enable (bit 5) is rejected as a whole unless bits 4 and 3 are also cleared.
- R6: A wake-up pulse sets bits 5, 4 and 3 to 1 on the next clock and leaves the crystal enable and the divide select unchanged. If a wake-up and an accepted control write arrive in the same cycle, the wake-up wins for bits 5:3 and the write sets the other fields.
- R7: Bit 7 of the control register always reads 0 whatever is written. Reads of the key register and of any other address return 0.
- R8: The core-clock enable is high for one reference cycle in every 2^S reference cycles, where S is the divide select: every cycle for S=0, and every 128 cycles for S=7.
- R9: A new divide select takes effect only after the period already in progress ends. That period completes at its old length, and the intervals after it use the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10.24 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | 8 | Read data (combinational) |
| wake_i | input | 1 | Wake-up event, one cycle |
| xtal_on | output | 1 | Crystal domain enable |
| pll_on | output | 1 | PLL domain enable |
| periph_on | output | 1 | Peripheral domain enable |
| core_on | output | 1 | Core domain enable |
| div_sel | output | 3 | Programmed core-clock divide select |
| hclk_en | output | 1 | Divided core-clock enable pulse |

## Verification
The bench builds the block with its default parameters. These are a 4-bit address, the key register at 0, the control register at 1 and a key value of 0x01, so each unlock sequence and each cancelling write can be aimed at exact addresses. With the 3-bit divide select, the longest period is 128 reference cycles. The extreme settings 0 and 7, and a change made in the middle of a 128-cycle period, can therefore all be measured within a short run.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int DIV_W = 3;

  typedef struct packed {
    logic             rsvd;
    logic             xtal;
    logic             pll;
    logic             peri;
    logic             core;
    logic [DIV_W-1:0] div;
  } pwr_ctrl_t;

  localparam pwr_ctrl_t CTRL_RESET = 8'h7B;

  // Nesting rules: peripherals only go down with the core,
  // the PLL only goes down with both.
  function automatic logic nest_ok(input pwr_ctrl_t v);
    logic peri_rule;
    logic pll_rule;
    peri_rule = v.peri | ~v.core;
    pll_rule  = v.pll | (~v.peri & ~v.core);
    return peri_rule & pll_rule;
  endfunction

endpackage

// File: rtl/pwr_unlock.sv
module pwr_unlock #(
  parameter int         ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = '0,
  parameter logic [7:0] KEY_VALUE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              armed
);

  logic armed_nxt;

  // Every bus write re-evaluates the unlock; only a correct key arms it.
  always_comb begin
    armed_nxt = armed;
    if (wr_en) begin
      armed_nxt = (wr_addr == KEY_ADDR) && (wr_data == KEY_VALUE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= armed_nxt;
    end
  end

endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_mode_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              armed,
  input  logic              wake,
  output pwr_ctrl_t         ctrl
);

  pwr_ctrl_t cand;
  pwr_ctrl_t ctrl_nxt;
  logic      accept;

  always_comb begin
    cand      = pwr_ctrl_t'(wr_data);
    cand.rsvd = 1'b0;
    accept    = wr_en && (wr_addr == CTRL_ADDR) && armed && nest_ok(cand);

    ctrl_nxt = ctrl;
    if (accept) begin
      ctrl_nxt = cand;
    end
    // Wake-up has the last word on the three restorable domains.
    if (wake) begin
      ctrl_nxt.pll  = 1'b1;
      ctrl_nxt.peri = 1'b1;
      ctrl_nxt.core = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RESET;
    end else if (accept || wake) begin
      ctrl <= ctrl_nxt;
    end
  end

endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div
  import pwr_mode_pkg::*;
#(
  parameter int SEL_W = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [SEL_W-1:0] act_sel, act_sel_nxt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit       = ~({CNT_W{1'b1}} << act_sel);
    tick        = (cnt == limit);
    cnt_nxt     = cnt + 1'b1;
    act_sel_nxt = act_sel;
    if (tick) begin
      cnt_nxt     = '0;
      act_sel_nxt = div_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_sel <= SEL_W'(CTRL_RESET.div);
    end else begin
      cnt     <= cnt_nxt;
      act_sel <= act_sel_nxt;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1,
  parameter logic [7:0]        KEY_VALUE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wake_i,
  output logic              xtal_on,
  output logic              pll_on,
  output logic              periph_on,
  output logic              core_on,
  output logic [DIV_W-1:0]  div_sel,
  output logic              hclk_en
);

  logic      armed;
  pwr_ctrl_t ctrl;

  pwr_unlock #(
    .ADDR_W   (ADDR_W),
    .KEY_ADDR (KEY_ADDR),
    .KEY_VALUE(KEY_VALUE)
  ) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .armed  (armed)
  );

  pwr_ctrl_reg #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .armed  (armed),
    .wake   (wake_i),
    .ctrl   (ctrl)
  );

  pwr_clk_div #(
    .SEL_W(DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_sel(ctrl.div),
    .tick   (hclk_en)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) begin
      rd_data = ctrl;
    end
  end

  assign xtal_on   = ctrl.xtal;
  assign pll_on    = ctrl.pll;
  assign periph_on = ctrl.peri;
  assign core_on   = ctrl.core;
  assign div_sel   = ctrl.div;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wake_i,
  input logic [7:0]        rd_data,
  input logic              xtal_on,
  input logic              pll_on,
  input logic              periph_on,
  input logic              core_on,
  input logic [2:0]        div_sel
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  assert_peri_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_on |-> !core_on);

  assert_pll_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |-> (!core_on && !periph_on));

  assert_wake_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (core_on && periph_on && pll_on));

  assert_wake_keeps_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i && !ctrl_wr) |=> ($stable(xtal_on) && $stable(div_sel)));

  assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !wake_i) |=>
      $stable({xtal_on, pll_on, periph_on, core_on, div_sel}));

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7]);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wake_i   (wake_i),
  .rd_data  (rd_data),
  .xtal_on  (xtal_on),
  .pll_on   (pll_on),
  .periph_on(periph_on),
  .core_on  (core_on),
  .div_sel  (div_sel)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int CLK_P = 98;
  localparam logic [3:0] A_KEY  = 4'h0;
  localparam logic [3:0] A_CTRL = 4'h1;
  localparam logic [3:0] A_OTHER = 4'h2;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic       wake_i;
  logic       xtal_on, pll_on, periph_on, core_on;
  logic [2:0] div_sel;
  logic       hclk_en;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    bit         is_rd;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wake_i   (wake_i),
    .xtal_on  (xtal_on),
    .pll_on   (pll_on),
    .periph_on(periph_on),
    .core_on  (core_on),
    .div_sel  (div_sel),
    .hclk_en  (hclk_en)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Monitor: pops expected items a quarter period after the falling edge.
  always begin
    @(negedge clk);
    #(CLK_P/4);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_rd ? rd_data : {1'b0, xtal_on, pll_on, periph_on, core_on, div_sel};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s %s actual=0x%02h expected=0x%02h",
                 it.req, it.is_rd ? "read" : "status", act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    rd_addr = a;
    sb_q.push_back('{1'b1, e, req});
  endtask

  task automatic expect_st(input logic [7:0] e, input string req);
    @(negedge clk);
    sb_q.push_back('{1'b0, e, req});
  endtask

  task automatic expect_both(input logic [7:0] e, input string req);
    expect_rd(A_CTRL, e, req);
    expect_st(e, req);
  endtask

  task automatic chk_int(input int act, input int e, input string req);
    n_cmp++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, e);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input logic wk);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    wake_i  = wk;
    @(negedge clk);
    wr_en   = 1'b0;
    wake_i  = 1'b0;
  endtask

  task automatic unlocked_wr(input logic [7:0] d);
    bus_wr(A_KEY, 8'h01, 1'b0);
    bus_wr(A_CTRL, d, 1'b0);
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
  endtask

  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!hclk_en);
  endtask

  initial begin
    int gap;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    wake_i  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_both(8'h7B, "R1");

    // R3 control write with no key
    bus_wr(A_CTRL, 8'h7D, 1'b0);
    expect_both(8'h7B, "R3");

    // R2 unlocked write accepted
    unlocked_wr(8'h7D);
    expect_both(8'h7D, "R2");

    // R7 bit 7 reads zero, other addresses read zero
    unlocked_wr(8'hFA);
    expect_both(8'h7A, "R7");
    expect_rd(A_KEY, 8'h00, "R7");
    expect_rd(A_OTHER, 8'h00, "R7");

    // R3 unlock cancelled by an intervening write
    bus_wr(A_KEY, 8'h01, 1'b0);
    bus_wr(A_OTHER, 8'h55, 1'b0);
    bus_wr(A_CTRL, 8'h79, 1'b0);
    expect_both(8'h7A, "R3");
    // R3 wrong key value
    bus_wr(A_KEY, 8'h02, 1'b0);
    bus_wr(A_CTRL, 8'h79, 1'b0);
    expect_both(8'h7A, "R3");
    // R3 a rejected control write also consumes the unlock
    bus_wr(A_KEY, 8'h01, 1'b0);
    bus_wr(A_CTRL, 8'h6A, 1'b0);
    bus_wr(A_CTRL, 8'h79, 1'b0);
    expect_both(8'h7A, "R3");

    // R4 peripherals down with core up: rejected whole
    unlocked_wr(8'h6D);
    expect_both(8'h7A, "R4");
    unlocked_wr(8'h62);
    expect_both(8'h62, "R4");

    // R5 PLL down without the others: rejected whole
    unlocked_wr(8'h7A);
    unlocked_wr(8'h5D);
    expect_both(8'h7A, "R5");
    unlocked_wr(8'h42);
    expect_both(8'h42, "R5");

    // R6 wake restores pll/peri/core only
    pulse_wake();
    expect_both(8'h7A, "R6");
    unlocked_wr(8'h05);
    expect_both(8'h05, "R6");
    pulse_wake();
    expect_both(8'h3D, "R6");
    // R6 wake in the same cycle as an accepted write
    unlocked_wr(8'h02);
    expect_both(8'h02, "R6");
    bus_wr(A_KEY, 8'h01, 1'b0);
    bus_wr(A_CTRL, 8'h45, 1'b1);
    expect_both(8'h7D, "R6");

    // R8 period for several selects
    foreach (sb_q[i]) begin end
    for (int s = 0; s < 8; s += 1) begin
      if (s == 0 || s == 2 || s == 7) begin
        unlocked_wr(8'h78 | 8'(s));
        next_pulse(gap);
        next_pulse(gap);
        next_pulse(gap);
        chk_int(gap, 1 << s, "R8");
      end
    end

    // R9 change mid-period: old period finishes, then new one applies
    unlocked_wr(8'h79);
    next_pulse(gap);
    chk_int(gap, 124, "R9");
    next_pulse(gap);
    chk_int(gap, 2, "R9");
    next_pulse(gap);
    chk_int(gap, 2, "R9");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule